// File: doc/BRIEF.md
# Two-out-of-five block codec

This block maps a 3-bit data value onto a constant-weight code in which every 5-bit word holds exactly two ones, and checks received 5-bit words against that code. Of the ten weight-two words, eight carry data and two are held in reserve. The encoder and the checker are independent paths that can be used side by side. Each path has its own valid strobe.

The checker counts the ones in a received word with a small adder tree. Any word whose count is not two raises a weight error. A weight-two word that carries no data raises a separate unused-word flag. A word that carries data returns its 3-bit value. Both paths are combinational, and a parameter adds one output register stage.

A corruption that turns a one into a zero and a zero into a one keeps the weight at two. The checker cannot see such a corruption. It returns the data of whatever legal word it receives.

Top module: `two_of_five_codec`

## Requirements
- R1: Every word the encoder emits with `enc_valid_out` high contains exactly two 1 bits.
- R2: Data value i maps to the i-th weight-two word in descending binary order: 0→11000, 1→10100, 2→10010, 3→10001, 4→01100, 5→01010, 6→01001, 7→00110.
- R3: The weight-two words 00101 and 00011 are never emitted by the encoder. When one of them is received, the checker sets `chk_unused`=1 and `chk_weight_err`=0.
- R4: The checker sets `chk_weight_err`=1 exactly when the received word does not contain two 1 bits. `chk_weight_err` and `chk_unused` are never high together.
- R5: For a used legal word, `chk_data` equals the value that encodes to that word. Whenever either flag is set, `chk_data` is 0.
- R6: With `REG_OUT`=1, each valid output rises one cycle after its valid input. The output fields load only on a valid input and otherwise hold. Reset (`rst_n`=0) clears all outputs to 0. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.
- R7: A received word reached from a legal word by one 1→0 flip and one 0→1 flip is accepted without any flag. For example, 11000 corrupted to 01010 decodes as data 5.
- R8: Every single-bit corruption of a legal word (weight one or three) raises `chk_weight_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_in | input | 1 | Encoder input strobe |
| enc_data | input | 3 | Data value to encode |
| enc_valid_out | output | 1 | Encoder output strobe |
| enc_word | output | 5 | Encoded codeword |
| chk_valid_in | input | 1 | Checker input strobe |
| chk_word | input | 5 | Received word |
| chk_valid_out | output | 1 | Checker output strobe |
| chk_weight_err | output | 1 | Received word does not have weight two |
| chk_unused | output | 1 | Received word is a legal word that carries no data |
| chk_data | output | 3 | Decoded data, zero when a flag is set |

## Verification
On every cycle, the assertions check several properties. Emitted words have weight two and never use the reserved pair. The two flags are mutually exclusive, and flagged results carry zero data. The weight flag agrees with a population count of the word sampled one cycle earlier, and each valid output follows its valid input by exactly one cycle.

Some behaviours can only be shown by the bench's scenarios. These are the exact data-to-word mapping, the decode of each of the 32 possible input words, the encode-then-decode loopback, the holding of outputs between strobes, and the silent acceptance of a swapped-bit double error.

// File: rtl/two_of_five_codec.sv
module two_of_five_codec #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_valid_in,
  input  logic [2:0] enc_data,
  output logic       enc_valid_out,
  output logic [4:0] enc_word,
  input  logic       chk_valid_in,
  input  logic [4:0] chk_word,
  output logic       chk_valid_out,
  output logic       chk_weight_err,
  output logic       chk_unused,
  output logic [2:0] chk_data
);

  logic [4:0] cw_next;
  logic [1:0] sum_lo, sum_hi;
  logic [2:0] ones;
  logic       werr_next, unused_next;
  logic [2:0] data_next, dec_idx;
  logic       dec_reserved;

  always_comb begin
    case (enc_data)
      3'd0:    cw_next = 5'b11000;
      3'd1:    cw_next = 5'b10100;
      3'd2:    cw_next = 5'b10010;
      3'd3:    cw_next = 5'b10001;
      3'd4:    cw_next = 5'b01100;
      3'd5:    cw_next = 5'b01010;
      3'd6:    cw_next = 5'b01001;
      default: cw_next = 5'b00110;
    endcase
  end

  assign sum_lo = {1'b0, chk_word[0]} + {1'b0, chk_word[1]};
  assign sum_hi = {1'b0, chk_word[2]} + {1'b0, chk_word[3]};
  assign ones   = {1'b0, sum_lo} + {1'b0, sum_hi} + {2'b00, chk_word[4]};

  always_comb begin
    dec_idx      = 3'd0;
    dec_reserved = 1'b0;
    case (chk_word)
      5'b10100: dec_idx = 3'd1;
      5'b10010: dec_idx = 3'd2;
      5'b10001: dec_idx = 3'd3;
      5'b01100: dec_idx = 3'd4;
      5'b01010: dec_idx = 3'd5;
      5'b01001: dec_idx = 3'd6;
      5'b00110: dec_idx = 3'd7;
      5'b00101, 5'b00011: dec_reserved = 1'b1;
      default: dec_idx = 3'd0;
    endcase
  end

  assign werr_next   = (ones != 3'd2);
  assign unused_next = !werr_next && dec_reserved;
  assign data_next   = (werr_next || dec_reserved) ? 3'd0 : dec_idx;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          enc_valid_out  <= 1'b0;
          enc_word       <= 5'd0;
          chk_valid_out  <= 1'b0;
          chk_weight_err <= 1'b0;
          chk_unused     <= 1'b0;
          chk_data       <= 3'd0;
        end else begin
          enc_valid_out <= enc_valid_in;
          chk_valid_out <= chk_valid_in;
          if (enc_valid_in) enc_word <= cw_next;
          if (chk_valid_in) begin
            chk_weight_err <= werr_next;
            chk_unused     <= unused_next;
            chk_data       <= data_next;
          end
        end
      end

      // R6: strobes follow inputs by one cycle
      p_enc_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_in |=> enc_valid_out);
      p_chk_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_in |=> !chk_valid_out);
      // R4: flag agrees with a population count of the sampled word
      p_weight_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_in |=> chk_weight_err == ($countones($past(chk_word)) != 2));
    end else begin : g_comb
      assign enc_valid_out  = enc_valid_in;
      assign enc_word       = cw_next;
      assign chk_valid_out  = chk_valid_in;
      assign chk_weight_err = werr_next;
      assign chk_unused     = unused_next;
      assign chk_data       = data_next;

      p_weight_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_in |-> chk_weight_err == ($countones(chk_word) != 2));
    end
  endgenerate

  p_enc_weight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_out |-> $countones(enc_word) == 2);
  p_enc_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_out |-> (enc_word != 5'b00101 && enc_word != 5'b00011));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_out |-> !(chk_weight_err && chk_unused));
  p_flag_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_out && (chk_weight_err || chk_unused)) |-> chk_data == 3'd0);

endmodule

// File: tb/two_of_five_codec_test.sv
module two_of_five_codec_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_valid_in = 1'b0, chk_valid_in = 1'b0;
  logic [2:0] enc_data = 3'd0;
  logic [4:0] chk_word = 5'd0;
  logic enc_valid_out, chk_valid_out, chk_weight_err, chk_unused;
  logic [4:0] enc_word;
  logic [2:0] chk_data;

  int checks = 0, errors = 0;
  logic e_ev = 0, e_cv = 0, e_err = 0, e_unu = 0;
  logic [4:0] e_word = 0;
  logic [2:0] e_data = 0;

  always #4 clk = ~clk;

  two_of_five_codec #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_in(enc_valid_in), .enc_data(enc_data),
    .enc_valid_out(enc_valid_out), .enc_word(enc_word),
    .chk_valid_in(chk_valid_in), .chk_word(chk_word),
    .chk_valid_out(chk_valid_out), .chk_weight_err(chk_weight_err),
    .chk_unused(chk_unused), .chk_data(chk_data));

  function automatic int nth_word(int n);
    int k = 0;
    for (int w = 31; w >= 0; w--)
      if ($countones(w[4:0]) == 2) begin
        if (k == n) return w;
        k++;
      end
    return -1;
  endfunction

  function automatic int word_index(int w);
    for (int n = 0; n < 10; n++) if (nth_word(n) == w) return n;
    return -1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 enc_valid", enc_valid_out, e_ev);
    chk("R1 R2 enc_word", enc_word, e_word);
    chk("R6 chk_valid", chk_valid_out, e_cv);
    chk("R4 R8 weight_err", chk_weight_err, e_err);
    chk("R3 unused", chk_unused, e_unu);
    chk("R5 data", chk_data, e_data);
  endtask

  task automatic step(bit ev, int d, bit cv, int w);
    @(negedge clk);
    compare_all();
    enc_valid_in = ev; enc_data = d[2:0];
    chk_valid_in = cv; chk_word = w[4:0];
    e_ev = ev; e_cv = cv;
    if (ev) e_word = nth_word(d)[4:0];
    if (cv) begin
      int idx = word_index(w);
      e_err  = ($countones(w[4:0]) != 2);
      e_unu  = (idx >= 8);
      e_data = (idx >= 0 && idx < 8) ? idx[2:0] : 3'd0;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();                      // R6 reset state
    rst_n = 1'b1;
    for (int w = 0; w < 32; w++) step(1'b0, 0, 1'b1, w);     // R4 R8 R3 R5 sweep
    for (int i = 0; i < 8; i++) step(1'b1, i, 1'b0, 0);      // R1 R2
    step(1'b0, 0, 1'b0, 0);
    step(1'b0, 0, 1'b0, 0);                                  // R6 hold
    for (int i = 0; i < 8; i++) begin                        // loopback
      step(1'b1, i, 1'b0, 0);
      step(1'b0, 0, 1'b1, nth_word(i));
    end
    step(1'b0, 0, 1'b1, 5'b01010);      // R7: 11000 with bits 4 and 1 swapped
    @(negedge clk);
    chk("R7 swap undetected err", chk_weight_err, 0);
    chk("R7 swap undetected unused", chk_unused, 0);
    chk("R7 swap data", chk_data, 5);
    step(1'b0, 0, 1'b1, 5'b11010);      // R8 single flip of 11000
    step(1'b0, 0, 1'b0, 0);
    rst_n = 1'b0;
    e_ev = 0; e_cv = 0; e_err = 0; e_unu = 0; e_word = 0; e_data = 0;
    @(negedge clk);
    compare_all();                      // R6 reset clears outputs
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule